// File: doc/BRIEF.md
# Master Clock Divider Controller

This block runs from a single master clock and produces three divided clock enables: one for the processor cores, one for the AXI interconnect and one for the AHB/APB peripheral bus. Each enable is a one-cycle pulse that repeats every 1, 2, 4 or 8 master cycles. A 6-bit configuration word selects the rate, with two bits per domain. All three enables come from one shared 3-bit phase counter, so a slower pulse always lands on a cycle where every faster pulse is also high.

Software writes the configuration through a simple write port. The block cleans up the written word before it stores it. A zero ratio in the peripheral field becomes divide by 2, because that bus cannot run at full rate. A word that would run the AXI domain faster than the cores is rejected and raises a sticky error flag. A write that passes is held in a pending slot. It takes effect only when the phase counter wraps to zero, so any setting can follow any other in one write and no domain sees a shortened or doubled pulse. The configuration in effect can be read back at any time.

Top module: `mclk_div_ctrl`

## Requirements
- R1: After reset the configuration in effect reads back 6'b10_01_00 (cores /1, AXI /2, peripheral /4), the error flag is 0, the phase counter is 0, and all three enables are high in the first cycle.
- R2: A 2-bit domain code k (00, 01, 10, 11) gives divide by 2^k. The domain's enable is high exactly when the low k bits of the phase counter are zero. The counter starts at 0 after reset and advances by one every master cycle.
- R3: Every enable is high when the phase counter is 0, and the AXI enable is never high while the core enable is low.
- R4: A written peripheral code of 00 is stored and read back as 01 (divide by 2). The other peripheral codes are kept as written.
- R5: The field layout is: bits 1:0 cores, bits 3:2 AXI, bits 5:4 peripheral. A write whose AXI code is numerically smaller than its core code is rejected: the configuration in effect and any pending word stay unchanged, and the error flag is 1 from the cycle after the write.
- R6: Once set, the error flag stays at 1 through later accepted writes until reset.
- R7: An accepted word becomes the configuration in effect only at the clock edge where the phase counter wraps from 7 to 0. Before that edge the old configuration still drives the enables and the readback. A write made in the cycle where the counter is 7 waits for the next wrap.
- R8: Any accepted word replaces any current configuration in one write, including a change of all fields at once.
- R9: When several accepted writes arrive before a wrap, the last one is the one applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the configuration word |
| cfg_wr_data | input | 6 | Written configuration word (cores 1:0, AXI 3:2, peripheral 5:4) |
| cfg_rd_data | output | 6 | Configuration currently in effect, after clean-up |
| cfg_err | output | 1 | Sticky flag: a write broke the AXI-versus-core rule |
| en_core | output | 1 | Clock enable for the processor cores |
| en_fabric | output | 1 | Clock enable for the AXI interconnect |
| en_periph | output | 1 | Clock enable for the AHB/APB peripheral bus |

## Verification
The bench builds the block with its default parameters: 2-bit codes and therefore a 3-bit phase counter and a reset word of 6'b10_01_00. At these values a full counter period is only eight cycles. Every code, every counter phase and the write that lands on phase 7 can be reached and checked cycle by cycle in a short run. The expected pulse pattern for each domain comes from the current configuration and the phase.

// File: rtl/mclk_div_pkg.sv
package mclk_div_pkg;

    localparam int FLD_W      = 2;
    localparam int NUM_DOM    = 3;
    localparam int CFG_W      = FLD_W * NUM_DOM;
    localparam int IDX_CORE   = 0;
    localparam int IDX_FAB    = 1;
    localparam int IDX_PERIPH = 2;
    localparam int CNT_W      = (1 << FLD_W) - 1;

    typedef logic [FLD_W-1:0] code_t;
    typedef logic [CFG_W-1:0] cfg_t;

    function automatic code_t field_of(input cfg_t word, input int idx);
        return word[idx*FLD_W +: FLD_W];
    endfunction

endpackage

// File: rtl/mclk_div_phase.sv
module mclk_div_phase #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] phase,
    output logic             wrap_next
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } phase_st_t;

    phase_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase     = st_q.cnt;
    assign wrap_next = &st_q.cnt;

    // R2: counter advances by exactly one every master cycle
    p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> phase == (CNT_W)'($past(phase) + 1'b1));

endmodule

// File: rtl/mclk_div_cfg.sv
module mclk_div_cfg
    import mclk_div_pkg::*;
#(
    parameter cfg_t RST_CFG = 6'b10_01_00
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  cfg_t wr_word,
    input  logic wrap_next,
    output cfg_t cfg_live,
    output logic err_flag
);

    typedef struct packed {
        cfg_t live;
        cfg_t pend;
        logic pend_vld;
        logic err;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    code_t core_c;
    code_t fab_c;
    code_t per_c;
    code_t per_eff;
    logic  word_ok;
    cfg_t  clean_word;

    // clean-up and rule check of the written word
    always_comb begin
        core_c     = field_of(wr_word, IDX_CORE);
        fab_c      = field_of(wr_word, IDX_FAB);
        per_c      = field_of(wr_word, IDX_PERIPH);
        per_eff    = (per_c == '0) ? code_t'(1) : per_c;
        word_ok    = (fab_c >= core_c);
        clean_word = wr_word;
        clean_word[IDX_PERIPH*FLD_W +: FLD_W] = per_eff;
    end

    always_comb begin
        st_d = st_q;
        if (wrap_next && st_q.pend_vld) begin
            st_d.live     = st_q.pend;
            st_d.pend_vld = 1'b0;
        end
        if (wr_en) begin
            if (word_ok) begin
                st_d.pend     = clean_word;
                st_d.pend_vld = 1'b1;
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.live     <= RST_CFG;
            st_q.pend     <= RST_CFG;
            st_q.pend_vld <= 1'b0;
            st_q.err      <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_live = st_q.live;
    assign err_flag = st_q.err;

    // R7: applied configuration moves only on the wrap edge
    p_live_at_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_live) |-> $past(wrap_next));

    // R6: error flag never clears without reset
    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    // R5: a rejected word leaves the error flag raised
    p_reject_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (field_of(wr_word, IDX_FAB) < field_of(wr_word, IDX_CORE))) |=> err_flag);

    // R5: configuration in effect never runs the AXI domain faster than the cores
    p_fab_not_faster_r5: assert property (@(posedge clk) disable iff (!rst_n)
        field_of(cfg_live, IDX_FAB) >= field_of(cfg_live, IDX_CORE));

    // R4: peripheral bus never runs at divide by 1
    p_periph_not_div1_r4: assert property (@(posedge clk) disable iff (!rst_n)
        field_of(cfg_live, IDX_PERIPH) != '0);

endmodule

// File: rtl/mclk_div_en.sv
module mclk_div_en
    import mclk_div_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic [CNT_W-1:0]   phase,
    input  cfg_t               cfg,
    output logic [NUM_DOM-1:0] en
);

    for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
        code_t            code;
        logic [CNT_W-1:0] mask;

        always_comb begin
            code  = field_of(cfg, g);
            mask  = (CNT_W)'((1 << code) - 1);
            en[g] = ((phase & mask) == '0);
        end
    end

endmodule

// File: rtl/mclk_div_ctrl.sv
module mclk_div_ctrl
    import mclk_div_pkg::*;
#(
    parameter cfg_t RST_CFG = 6'b10_01_00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [CFG_W-1:0] cfg_wr_data,
    output logic [CFG_W-1:0] cfg_rd_data,
    output logic             cfg_err,
    output logic             en_core,
    output logic             en_fabric,
    output logic             en_periph
);

    logic [CNT_W-1:0]   phase;
    logic               wrap_next;
    cfg_t               cfg_live;
    logic [NUM_DOM-1:0] en_vec;

    mclk_div_phase #(
        .CNT_W (CNT_W)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .wrap_next (wrap_next)
    );

    mclk_div_cfg #(
        .RST_CFG (RST_CFG)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr_en),
        .wr_word   (cfg_wr_data),
        .wrap_next (wrap_next),
        .cfg_live  (cfg_live),
        .err_flag  (cfg_err)
    );

    mclk_div_en #(
        .CNT_W (CNT_W)
    ) u_en (
        .phase (phase),
        .cfg   (cfg_live),
        .en    (en_vec)
    );

    assign cfg_rd_data = cfg_live;
    assign en_core     = en_vec[IDX_CORE];
    assign en_fabric   = en_vec[IDX_FAB];
    assign en_periph   = en_vec[IDX_PERIPH];

    // R3: all domains pulse together at phase zero
    p_all_on_at_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == '0) |-> (en_core && en_fabric && en_periph));

    // R3: AXI pulse always coincides with a core pulse
    p_fab_inside_core_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en_fabric |-> en_core);

endmodule

// File: tb/mclk_div_ctrl_test.sv
module mclk_div_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr_en = 1'b0;
    logic [5:0] cfg_wr_data = '0;
    logic [5:0] cfg_rd_data;
    logic       cfg_err;
    logic       en_core, en_fabric, en_periph;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int wd = 0;

    logic [5:0] exp_cfg;
    logic       exp_err;

    typedef struct {
        int         at;
        logic [5:0] cfg;
        logic       err;
        logic [2:0] en;
        string      tag;
    } item_t;

    item_t sb[$];

    mclk_div_ctrl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_data (cfg_wr_data),
        .cfg_rd_data (cfg_rd_data),
        .cfg_err     (cfg_err),
        .en_core     (en_core),
        .en_fabric   (en_fabric),
        .en_periph   (en_periph)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    function automatic logic [2:0] exp_en(input logic [5:0] c, input int ph);
        logic [2:0] r;
        for (int d = 0; d < 3; d++) begin
            int k;
            k = int'(c[2*d +: 2]);
            r[d] = ((ph % (1 << k)) == 0);
        end
        return r;
    endfunction

    function automatic logic [5:0] clean(input logic [5:0] w);
        logic [5:0] r;
        r = w;
        if (r[5:4] == 2'b00) r[5:4] = 2'b01;
        return r;
    endfunction

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic push(input int at, input logic [5:0] c, input logic e, input string tag);
        item_t it;
        it.at  = at;
        it.cfg = c;
        it.err = e;
        it.en  = exp_en(c, at % 8);
        it.tag = tag;
        sb.push_back(it);
    endtask

    // monitor: compares scoreboard items in the cycle they are due
    always @(negedge clk) begin
        item_t it;
        logic [2:0] act;
        while (sb.size() > 0 && sb[0].at == cyc) begin
            it  = sb.pop_front();
            act = {en_periph, en_fabric, en_core};
            total++;
            if (act !== it.en || cfg_rd_data !== it.cfg || cfg_err !== it.err) begin
                bad++;
                $display("FAIL %s cyc=%0d en=%b cfg=%b err=%b expected en=%b cfg=%b err=%b",
                         it.tag, cyc, act, cfg_rd_data, cfg_err, it.en, it.cfg, it.err);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            finish_up();
        end
    end

    task automatic wait_drain();
        while (sb.size() > 0) @(negedge clk);
    endtask

    task automatic align_to(input int ph);
        while (cyc % 8 != ph) @(negedge clk);
    endtask

    // single write; expected trace pushed up to eight cycles past the wrap
    task automatic write_cfg(input logic [5:0] w, input string tag);
        int c, last;
        logic ok;
        c = cyc;
        cfg_wr_en   = 1'b1;
        cfg_wr_data = w;
        ok = (w[3:2] >= w[1:0]);
        if (ok) begin
            last = c + 1;
            while (last % 8 != 7) last++;
            for (int t = c + 1; t <= last; t++) push(t, exp_cfg, exp_err, {tag, " old cfg held (R7)"});
            exp_cfg = clean(w);
            for (int t = last + 1; t <= last + 8; t++) push(t, exp_cfg, exp_err, tag);
        end else begin
            exp_err = 1'b1;
            for (int t = c + 1; t <= c + 8; t++) push(t, exp_cfg, exp_err, tag);
        end
        @(negedge clk);
        cfg_wr_en = 1'b0;
        wait_drain();
    endtask

    task automatic check_reset(input string tag);
        total++;
        if (cfg_rd_data !== 6'b10_01_00 || cfg_err !== 1'b0 ||
            {en_periph, en_fabric, en_core} !== 3'b111) begin
            bad++;
            $display("FAIL %s cfg=%b err=%b en=%b expected cfg=100100 err=0 en=111",
                     tag, cfg_rd_data, cfg_err, {en_periph, en_fabric, en_core});
        end
    endtask

    initial begin
        int c, last;
        exp_cfg = 6'b10_01_00;
        exp_err = 1'b0;
        repeat (3) @(negedge clk);
        check_reset("R1 reset state");
        rst_n = 1'b1;
        // R1 R2 R3: reset rates over one counter period
        for (int t = 0; t < 16; t++) push(t, exp_cfg, exp_err, "R1 R2 reset rates");
        wait_drain();

        align_to(3);
        write_cfg(6'b00_11_10, "R4 periph 00 forced to 01, R2 /4 /8");
        align_to(1);
        write_cfg(6'b11_11_11, "R8 all fields to /8");
        align_to(4);
        write_cfg(6'b00_00_00, "R8 all fields from /8 to fastest, R4");
        align_to(2);
        write_cfg(6'b01_00_01, "R5 AXI faster than cores rejected");
        align_to(5);
        write_cfg(6'b11_01_00, "R6 error stays after accepted write");
        align_to(7);
        write_cfg(6'b10_10_01, "R7 write at phase 7 waits a full period");

        // R9: two writes before one wrap, last one wins
        align_to(2);
        c = cyc;
        cfg_wr_en   = 1'b1;
        cfg_wr_data = 6'b01_01_01;
        @(negedge clk);
        cfg_wr_data = 6'b11_10_10;
        last = c + 5;
        for (int t = c + 1; t <= last; t++) push(t, exp_cfg, exp_err, "R9 old cfg before wrap");
        exp_cfg = clean(6'b11_10_10);
        for (int t = last + 1; t <= last + 8; t++) push(t, exp_cfg, exp_err, "R9 last write wins");
        @(negedge clk);
        cfg_wr_en = 1'b0;
        wait_drain();

        // R6 R1: only reset clears the error and restores the default
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_reset("R6 R1 reset clears error");
        exp_cfg = 6'b10_01_00;
        exp_err = 1'b0;
        rst_n = 1'b1;
        for (int t = 0; t < 8; t++) push(t, exp_cfg, exp_err, "R1 rates after second reset");
        wait_drain();

        finish_up();
    end

endmodule